// File: doc/BRIEF.md
# Serially Programmed Sine Synthesizer

This block is a direct digital synthesis core. It produces a stream of signed digital sine samples for a DAC that sits outside the block. A host programs the output frequency by shifting a 16-bit tuning word in over a three-wire serial port: a shift clock, a data line and a load strobe. Each word is collected in a shift register and moves into a holding register only when the load strobe rises.

A clock-enable divider fires once every four system clocks. On each firing, a 21-bit phase accumulator adds the held word. The output frequency is therefore fclk·D/2^23, and both the step size and the lowest nonzero frequency are fclk/2^23.

The top ten accumulator bits form a phase. A 256-entry quarter-wave magnitude table, mirrored and sign-folded by quadrant, turns that phase into a 12-bit signed sample. A one-bit amplitude select passes the sample at full scale or halves it. Each new sample comes with a one-cycle valid pulse.

Top module: `sine_synth_top`

## Requirements
- R1: While `rst_n` is low, and through the first two rising clock edges after it rises, `sample_o` reads 0 and `sample_vld_o` reads 0. The accumulator, the divider and the holding register are cleared.
- R2: After reset, `sample_vld_o` is high for exactly one cycle in every four, so consecutive pulses are four cycles apart.
- R3: On every rising transition of `ser_clk` (seen by the system clock), `ser_data` is shifted into the shift register at the least significant end. A 16-bit word is therefore sent most significant bit first.
- R4: Shifting bits in does not change the held word or the sample sequence. Only a rising transition of `ser_load` copies the shift register into the holding register.
- R5: The phase accumulator is 21 bits wide and changes only on the cycles when a sample is issued. On each of those cycles it adds the held word, with the sum taken modulo 2^21.
- R6: The phase p is accumulator bits [20:11]. Its full-scale sample is round(2047·|sin(2π(p+0.5)/1024)|), negated when the sine is negative. This is realised as a quarter table addressed by p[7:0], with the address mirrored when p[8] is 1 and the value negated when p[9] is 1.
- R7: When `gain_full` is 1 the sample is the full-scale value. When it is 0 the sample is the full-scale value arithmetically shifted right by one bit.
- R8: With a held word of zero the phase does not move, so every sample equals the first one.
- R9: The sample presented while `sample_vld_o` is high is computed from the accumulator value after that cycle's addition, using `gain_full` as it stood on the preceding clock edge. `sample_o` holds between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising transition |
| ser_data | input | 1 | Serial data bit, most significant bit first |
| ser_load | input | 1 | Load strobe; its rising transition copies the shift register into the holding register |
| gain_full | input | 1 | 1 gives full amplitude, 0 gives half amplitude |
| sample_o | output | 12 | Two's-complement sine sample |
| sample_vld_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
The hardest situation to reach from the ports is a shift register that holds a partly or fully shifted new word while the old held word still drives the accumulator. The stimulus shifts a complete word in without a load strobe and runs several hundred cycles, so a sample stream that changes prematurely is exposed. Every quadrant of the folded table is swept with a coarse step, and a word of 0xFFFF forces accumulator wraparound. Gain is toggled asynchronously to the sample pulses, so the edge at which the amplitude is sampled is exercised.

// File: rtl/sine_pkg.sv
package sine_pkg;
  localparam int WORD_W  = 16;
  localparam int ACC_W   = 21;
  localparam int PHASE_W = 10;
  localparam int OUT_W   = 12;
  localparam int DIV     = 4;
  localparam int LUT_AW  = PHASE_W - 2;
  localparam int MAG_W   = OUT_W - 1;
  localparam int CNT_W   = $clog2(DIV);

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [ACC_W-1:0]   acc_t;
  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic signed [OUT_W-1:0] samp_t;
endpackage

// File: rtl/sine_ser_loader.sv
module sine_ser_loader
  import sine_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ser_clk,
  input  logic  ser_data,
  input  logic  ser_load,
  output word_t hold_word
);
  logic  sclk_q, sclk_d;
  logic  load_q, load_d;
  word_t shift_q, shift_d;
  word_t hold_q, hold_d;
  logic  shift_en, load_en;

  always_comb begin
    shift_en = ser_clk & ~sclk_q;
    load_en  = ser_load & ~load_q;
    sclk_d   = ser_clk;
    load_d   = ser_load;
    shift_d  = shift_q;
    hold_d   = hold_q;
    if (shift_en) shift_d = {shift_q[WORD_W-2:0], ser_data};
    if (load_en)  hold_d  = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      load_q  <= 1'b0;
      shift_q <= '0;
      hold_q  <= '0;
    end else begin
      sclk_q  <= sclk_d;
      load_q  <= load_d;
      shift_q <= shift_d;
      hold_q  <= hold_d;
    end
  end

  assign hold_word = hold_q;
endmodule

// File: rtl/sine_phase_accum.sv
module sine_phase_accum
  import sine_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t step,
  output logic  tick,
  output acc_t  acc_q,
  output acc_t  acc_nxt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  acc_t acc_d;

  always_comb begin
    tick    = (cnt_q == CNT_W'(DIV - 1));
    cnt_d   = cnt_q + CNT_W'(1);
    acc_nxt = acc_q + acc_t'(step);
    acc_d   = tick ? acc_nxt : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/sine_quarter_lut.sv
module sine_quarter_lut
  import sine_pkg::*;
(
  input  phase_t phase,
  output samp_t  value
);
  localparam int  ENTRIES = 2 ** LUT_AW;
  localparam real AMP     = real'(2 ** MAG_W - 1);
  localparam real HALF_PI = 1.5707963267948966;

  logic [MAG_W-1:0] mag_rom [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_rom
    localparam real ANG = HALF_PI * (real'(i) + 0.5) / real'(ENTRIES);
    localparam int  MAG = $rtoi(AMP * $sin(ANG) + 0.5);
    assign mag_rom[i] = MAG[MAG_W-1:0];
  end

  logic [LUT_AW-1:0] addr;
  logic [MAG_W-1:0]  mag;
  samp_t             pos;

  always_comb begin
    addr  = phase[PHASE_W-2] ? ~phase[LUT_AW-1:0] : phase[LUT_AW-1:0];
    mag   = mag_rom[addr];
    pos   = samp_t'({1'b0, mag});
    value = phase[PHASE_W-1] ? -pos : pos;
  end
endmodule

// File: rtl/sine_synth_top.sv
module sine_synth_top
  import sine_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_load,
  input  logic        gain_full,
  output logic [11:0] sample_o,
  output logic        sample_vld_o
);
  logic  rst_s1, rst_s2;
  word_t hold_word;
  logic  tick;
  acc_t  acc_q, acc_nxt;
  samp_t full_val, samp_d, samp_q;
  logic  vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  sine_ser_loader u_load (
    .clk       (clk),
    .rst_n     (rst_s2),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_load  (ser_load),
    .hold_word (hold_word)
  );

  sine_phase_accum u_acc (
    .clk     (clk),
    .rst_n   (rst_s2),
    .step    (hold_word),
    .tick    (tick),
    .acc_q   (acc_q),
    .acc_nxt (acc_nxt)
  );

  sine_quarter_lut u_lut (
    .phase (acc_nxt[ACC_W-1 -: PHASE_W]),
    .value (full_val)
  );

  always_comb begin
    samp_d = samp_q;
    if (tick) samp_d = gain_full ? full_val : (full_val >>> 1);
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      samp_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      samp_q <= samp_d;
      vld_q  <= tick;
    end
  end

  assign sample_o     = samp_q;
  assign sample_vld_o = vld_q;
endmodule

// File: rtl/sine_synth_chk.sv
module sine_synth_chk
  import sine_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              vld,
  input logic              gain,
  input logic [OUT_W-1:0]  sample,
  input logic [WORD_W-1:0] hold_word,
  input logic [ACC_W-1:0]  acc
);
  AST_VLD_GAP1: assert property (@(posedge clk) disable iff (!rst_n) vld |=> !vld); // R2
  AST_VLD_GAP3: assert property (@(posedge clk) disable iff (!rst_n) vld |=> ##2 !vld); // R2
  AST_ACC_STILL: assert property (@(posedge clk) disable iff (!rst_n) !vld |-> $stable(acc)); // R5
  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (hold_word == '0) |=> $stable(acc)); // R8
  AST_SAMPLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n) !vld |-> $stable(sample)); // R9
  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !$past(gain)) |-> ($signed(sample) >= -1024 && $signed(sample) <= 1023)); // R7
endmodule

bind sine_synth_top sine_synth_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vld       (sample_vld_o),
  .gain      (gain_full),
  .sample    (sample_o),
  .hold_word (hold_word),
  .acc       (acc_q)
);

// File: tb/sine_synth_top_tb.sv
module sine_synth_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, gain_full = 1'b1;
  logic [11:0] sample_o;
  logic        sample_vld_o;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  sine_synth_top u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .gain_full(gain_full),
    .sample_o(sample_o), .sample_vld_o(sample_vld_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ref_sample(input int acc, input bit g);
    int  p, mag, v;
    real s;
    p   = (acc >> 11) & 1023;
    s   = $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0);
    mag = $rtoi(2047.0 * (s < 0.0 ? -s : s) + 0.5);
    v   = (s < 0.0) ? -mag : mag;
    if (!g) v = v >>> 1;
    return v;
  endfunction

  // behavioural reference model
  bit m_rs1, m_rs2, m_sclk, m_load, m_vld;
  int m_sreg, m_hold, m_cnt, m_acc, m_samp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_sclk = 0; m_load = 0; m_vld = 0;
      m_sreg = 0; m_hold = 0; m_cnt = 0; m_acc = 0; m_samp = 0;
    end else begin
      if (!m_rs2) begin
        m_sclk = 0; m_load = 0; m_vld = 0;
        m_sreg = 0; m_hold = 0; m_cnt = 0; m_acc = 0; m_samp = 0;
      end else begin
        int old_sreg, old_hold;
        old_sreg = m_sreg; old_hold = m_hold;
        if (ser_clk && !m_sclk) m_sreg = ((m_sreg << 1) | int'(ser_data)) & 16'hFFFF;
        if (ser_load && !m_load) m_hold = old_sreg;
        m_sclk = ser_clk; m_load = ser_load;
        m_vld = (m_cnt == 3);
        m_cnt = (m_cnt + 1) % 4;
        if (m_vld) begin
          m_acc  = (m_acc + old_hold) % (1 << 21);
          m_samp = ref_sample(m_acc, gain_full);
        end
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  // per-cycle comparison, sampled mid-cycle
  int gap = 0;
  bit seen = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sample_vld_o == m_vld, {tag, " R2 R9 valid"}, int'(sample_vld_o), int'(m_vld));
      check($signed(sample_o) == m_samp, {tag, " R5 R6 R7 R9 sample"}, int'($signed(sample_o)), m_samp);
      if (sample_vld_o) begin
        if (seen) check(gap == 4, "R2 pulse spacing", gap, 4);
        seen = 1; gap = 1;
      end else gap++;
    end
  end

  task automatic shift_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i];
      @(negedge clk); ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_load();
    @(negedge clk); ser_load = 1'b1;
    @(negedge clk); ser_load = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first;
    wait_cyc(3);
    check(sample_o == 0 && !sample_vld_o, "R1 outputs in reset", int'(sample_o), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(sample_o == 0 && !sample_vld_o, "R1 outputs during sync", int'(sample_o), 0);
    @(negedge clk);
    check(!sample_vld_o, "R1 no pulse during sync", int'(sample_vld_o), 0);

    tag = "R8";
    wait_cyc(6);
    first = int'($signed(sample_o));
    check(first == ref_sample(0, 1), "R8 first sample with zero word", first, ref_sample(0, 1));
    wait_cyc(40);
    check(int'($signed(sample_o)) == first, "R8 phase held", int'($signed(sample_o)), first);

    tag = "R3";
    shift_word(16'h1000); pulse_load();
    wait_cyc(2200);

    tag = "R7";
    for (int k = 0; k < 40; k++) begin
      gain_full = ~gain_full;
      wait_cyc(7 + (k % 5));
    end
    gain_full = 1'b1;

    tag = "R4";
    shift_word(16'h0003);
    first = int'($signed(sample_o));
    wait_cyc(300);
    pulse_load();
    wait_cyc(400);

    tag = "R5";
    shift_word(16'hFFFF); pulse_load();
    gain_full = 1'b0;
    wait_cyc(600);
    gain_full = 1'b1;
    shift_word(16'h8001); pulse_load();
    wait_cyc(600);

    tag = "R6";
    shift_word(16'h0800); pulse_load();
    wait_cyc(4200);

    tag = "R1";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(sample_o == 0 && !sample_vld_o, "R1 outputs after second reset", int'(sample_o), 0);
    @(negedge clk); rst_n = 1'b1; seen = 0;
    tag = "R8";
    wait_cyc(60);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule